// File: doc/BRIEF.md
# SPI Host Command Sequencer with Minimum-Gap Enforcement

This block is the host side of a four-wire SPI link to a register-based peripheral. It accepts one register command at a time through a valid/ready handshake. Each command is a read or a write, with an address and a data byte. For each command the block produces one chip-select frame: the direction bit and address go out first, then the data byte. On a write the block shifts the data byte out, and on a read it samples the data byte from MISO.

The peripheral has strict minimum timing gaps. The block enforces all of them by counting system-clock cycles set by parameters:
- chip-select lead before the first clock edge;
- address-to-read-data pause;
- chip-select lag after the last clock edge, with separate values for reads and writes;
- inter-command gap, which depends on the previous command and the next one.

Two longer holdoffs are also enforced. One follows a read marked as a burst read. The other follows a write to the peripheral's reset register. Because every gap is timed inside the block, a caller can present commands back-to-back and leave the spacing to it.

Top module: `spi_gap_host`

## Requirements
- R1: Each accepted command produces one frame: spi_ncs low, then 16 spi_sclk cycles, with spi_sclk idle high. The first byte is {direction, addr[6:0]}, where direction 1 means write and 0 means read. The second byte is the write data, or zero on a read. Bits go out MSB first, and spi_mosi changes only when spi_sclk falls.
- R2: The first falling spi_sclk edge of a frame comes exactly T_LEAD clock cycles after spi_ncs falls.
- R3: Every low phase of spi_sclk lasts HALF_CYC cycles. Every high phase lasts HALF_CYC cycles, except where R5 or R6 extends it.
- R4: On a read, spi_miso is sampled at each rising spi_sclk edge of the second byte, MSB first. rd_data is presented with a one-cycle rd_valid pulse in the first cycle spi_ncs is high again. rd_valid never rises at any other time and never on a write.
- R5: On a read, the time from the last rising edge of the address byte to the first falling edge of the data byte is HALF_CYC + T_ADDR_DATA cycles.
- R6: From the last rising spi_sclk edge to spi_ncs rising takes HALF_CYC + T_LAG_RD cycles on a read and HALF_CYC + T_LAG_WR cycles on a write.
- R7: After a write, spi_ncs stays high at least T_WW cycles before a following write and at least T_WR cycles before a following read.
- R8: After a normal read, spi_ncs stays high at least T_RD_NEXT cycles. After a burst read it stays high at least the larger of T_RD_NEXT and T_BURST_EXIT.
- R9: After a write to address RST_ADDR, spi_ncs stays high at least T_RESET_HOLD cycles before any command.
- R10: cmd_ready is low while a frame is in progress or the required gap is still running. A command held valid is accepted in the first cycle the gap allows, so spi_ncs is then high for exactly the gap plus one cycle.
- R11: busy is high throughout every frame. After a frame ends, busy stays high for exactly the longest gap that the finished command can impose, counted from spi_ncs rising.
- R12: After reset, spi_ncs and spi_sclk are high, busy and rd_valid are low, and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_burst | input | 1 | Read uses the burst exit holdoff |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DATA_W | Read result |
| busy | output | 1 | Frame or trailing gap in progress |
| spi_ncs | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Host-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-host data |

## Verification
Every waveform interval is registered, so each one has an exact cycle count, and the bench compares against that count rather than a bound:
- the lead is T_LEAD;
- each clock phase is HALF_CYC;
- the address-to-data pause is HALF_CYC + T_ADDR_DATA;
- the release lag is HALF_CYC plus the read or write lag;
- rd_valid appears in the very sample where spi_ncs is first seen high.

For the inter-command gap with the next command held valid, spi_ncs must be seen high for exactly the required gap plus one sample. When the caller paused instead, the gap is only required to reach that length. The busy tail is counted sample by sample from the release of spi_ncs. A bench-side peripheral model shifts response bytes onto spi_miso after falling edges, so read data is checked against a value the bench derives from the captured address.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_LOW,
      ST_HIGH,
      ST_ADGAP,
      ST_LAG
   } seq_state_t;

   // Kind of the most recently finished frame; selects the next gap.
   typedef enum logic [2:0] {
      K_NONE,
      K_WRITE,
      K_READ,
      K_BURST,
      K_RESET
   } gap_kind_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_gap_phase.sv
// Down-counter that times one waveform phase.
module spi_gap_phase #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/spi_gap_holdoff.sv
// Counts cycles since chip select was released and decides whether the
// next command, given its direction, may start.
module spi_gap_holdoff
   import spi_gap_pkg::*;
#(
   parameter int T_WW         = 1500,
   parameter int T_WR         = 1000,
   parameter int T_RD_NEXT    = 25,
   parameter int T_BURST_EXIT = 25,
   parameter int T_RESET_HOLD = 1150000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  gap_kind_t kind_in,
   input  logic      next_write,
   output logic      ok_next,
   output logic      quiet
);

   localparam int T_BX  = imax(T_RD_NEXT, T_BURST_EXIT);
   localparam int T_WMX = imax(T_WW, T_WR);
   localparam int HMAX  = imax(imax(T_WMX, T_BX), T_RESET_HOLD);
   localparam int HW    = $clog2(HMAX + 1);

   logic [HW-1:0] elapsed;
   gap_kind_t     kind;
   logic [HW-1:0] need;
   logic [HW-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= HW'(HMAX);
         kind    <= K_NONE;
      end else if (restart) begin
         elapsed <= '0;
         kind    <= kind_in;
      end else if (elapsed != HW'(HMAX)) begin
         elapsed <= elapsed + 1'b1;
      end
   end

   always_comb begin
      case (kind)
         K_WRITE: begin
            need = next_write ? HW'(T_WW) : HW'(T_WR);
            hold = HW'(T_WMX);
         end
         K_READ: begin
            need = HW'(T_RD_NEXT);
            hold = HW'(T_RD_NEXT);
         end
         K_BURST: begin
            need = HW'(T_BX);
            hold = HW'(T_BX);
         end
         K_RESET: begin
            need = HW'(T_RESET_HOLD);
            hold = HW'(T_RESET_HOLD);
         end
         default: begin
            need = '0;
            hold = '0;
         end
      endcase
   end

   assign ok_next = (elapsed >= need);
   assign quiet   = (elapsed >= hold);

endmodule

// File: rtl/spi_gap_host.sv
module spi_gap_host
   import spi_gap_pkg::*;
#(
   parameter int          ADDR_W       = 7,
   parameter int          DATA_W       = 8,
   parameter int          HALF_CYC     = 13,
   parameter int          T_LEAD       = 6,
   parameter int          T_ADDR_DATA  = 200,
   parameter int          T_LAG_RD     = 6,
   parameter int          T_LAG_WR     = 1000,
   parameter int          T_WW         = 1500,
   parameter int          T_WR         = 1000,
   parameter int          T_RD_NEXT    = 25,
   parameter int          T_BURST_EXIT = 25,
   parameter int          T_RESET_HOLD = 1150000,
   parameter logic [ADDR_W-1:0] RST_ADDR = 7'h3A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic              cmd_burst,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              spi_ncs,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int A_BITS = ADDR_W + 1;
   localparam int FRAME  = A_BITS + DATA_W;
   localparam int BCW    = $clog2(FRAME);
   localparam int PMAX   = imax(imax(HALF_CYC, T_LEAD),
                                imax(T_ADDR_DATA, imax(T_LAG_RD, T_LAG_WR)));
   localparam int PCW    = $clog2(PMAX + 1);

   // Elaboration-time parameter checks
   generate
      if (HALF_CYC < 1 || T_LEAD < 1 || T_ADDR_DATA < 1) begin : g_bad_phase
         $error("spi_gap_host: phase lengths must be at least one cycle");
      end
      if (T_LAG_RD < 1 || T_LAG_WR < 1) begin : g_bad_lag
         $error("spi_gap_host: release lags must be at least one cycle");
      end
      if (T_WW < 1 || T_WR < 1 || T_RD_NEXT < 1 || T_BURST_EXIT < 1 ||
          T_RESET_HOLD < 1) begin : g_bad_gap
         $error("spi_gap_host: inter-command gaps must be at least one cycle");
      end
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
         $error("spi_gap_host: unsupported field widths");
      end
   endgenerate

   seq_state_t        st;
   logic [FRAME-1:0]  sh;
   logic [BCW-1:0]    bit_i;
   logic [DATA_W-1:0] rx;
   logic              is_wr, is_burst, is_rst;
   logic              ncs_q, sclk_q, mosi_q;
   logic              ph_load, ph_zero;
   logic [PCW-1:0]    ph_val;
   logic              ho_restart, ok_next, quiet;
   gap_kind_t         kind_done;
   logic              accept, last_bit, addr_end;

   assign cmd_ready = (st == ST_IDLE) && ok_next;
   assign accept    = cmd_valid && cmd_ready;
   assign busy      = (st != ST_IDLE) || !quiet;
   assign last_bit  = (bit_i == BCW'(FRAME - 1));
   assign addr_end  = (bit_i == BCW'(A_BITS - 1)) && !is_wr;
   assign kind_done = is_rst ? K_RESET : is_wr ? K_WRITE :
                      is_burst ? K_BURST : K_READ;

   spi_gap_phase #(.CW(PCW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .zero     (ph_zero)
   );

   spi_gap_holdoff #(
      .T_WW         (T_WW),
      .T_WR         (T_WR),
      .T_RD_NEXT    (T_RD_NEXT),
      .T_BURST_EXIT (T_BURST_EXIT),
      .T_RESET_HOLD (T_RESET_HOLD)
   ) u_holdoff (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (ho_restart),
      .kind_in    (kind_done),
      .next_write (cmd_write),
      .ok_next    (ok_next),
      .quiet      (quiet)
   );

   // Phase timer loads and the holdoff restart
   always_comb begin
      ph_load    = 1'b0;
      ph_val     = '0;
      ho_restart = 1'b0;
      case (st)
         ST_IDLE: if (accept) begin
            ph_load = 1'b1;
            ph_val  = PCW'(T_LEAD - 1);
         end
         ST_LEAD, ST_LOW, ST_ADGAP: if (ph_zero) begin
            ph_load = 1'b1;
            ph_val  = PCW'(HALF_CYC - 1);
         end
         ST_HIGH: if (ph_zero) begin
            ph_load = 1'b1;
            if (last_bit)
               ph_val = is_wr ? PCW'(T_LAG_WR - 1) : PCW'(T_LAG_RD - 1);
            else if (addr_end)
               ph_val = PCW'(T_ADDR_DATA - 1);
            else
               ph_val = PCW'(HALF_CYC - 1);
         end
         ST_LAG: ho_restart = ph_zero;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sh       <= '0;
         bit_i    <= '0;
         rx       <= '0;
         is_wr    <= 1'b0;
         is_burst <= 1'b0;
         is_rst   <= 1'b0;
         ncs_q    <= 1'b1;
         sclk_q   <= 1'b1;
         mosi_q   <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         case (st)
            ST_IDLE: if (accept) begin
               st       <= ST_LEAD;
               ncs_q    <= 1'b0;
               bit_i    <= '0;
               sh       <= {cmd_write, cmd_addr,
                            cmd_write ? cmd_wdata : {DATA_W{1'b0}}};
               is_wr    <= cmd_write;
               is_burst <= !cmd_write && cmd_burst;
               is_rst   <= cmd_write && (cmd_addr == RST_ADDR);
            end
            ST_LEAD: if (ph_zero) begin
               st     <= ST_LOW;
               sclk_q <= 1'b0;
               mosi_q <= sh[FRAME-1];
            end
            ST_LOW: if (ph_zero) begin
               st     <= ST_HIGH;
               sclk_q <= 1'b1;
               if (!is_wr && bit_i >= BCW'(A_BITS))
                  rx <= {rx[DATA_W-2:0], spi_miso};
            end
            ST_HIGH: if (ph_zero) begin
               if (last_bit) begin
                  st <= ST_LAG;
               end else begin
                  bit_i <= bit_i + 1'b1;
                  sh    <= sh << 1;
                  if (addr_end) begin
                     st <= ST_ADGAP;
                  end else begin
                     st     <= ST_LOW;
                     sclk_q <= 1'b0;
                     mosi_q <= sh[FRAME-2];
                  end
               end
            end
            ST_ADGAP: if (ph_zero) begin
               st     <= ST_LOW;
               sclk_q <= 1'b0;
               mosi_q <= sh[FRAME-1];
            end
            ST_LAG: if (ph_zero) begin
               st    <= ST_IDLE;
               ncs_q <= 1'b1;
               if (!is_wr) begin
                  rd_valid <= 1'b1;
                  rd_data  <= rx;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign spi_ncs  = ncs_q;
   assign spi_sclk = sclk_q;
   assign spi_mosi = mosi_q;

endmodule

// File: rtl/spi_gap_host_chk.sv
module spi_gap_host_chk #(
   parameter int T_LEAD = 6
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_ready,
   input logic rd_valid,
   input logic busy,
   input logic spi_ncs,
   input logic spi_sclk,
   input logic spi_mosi
);

   logic [15:0] lead_cnt;
   logic        edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_cnt  <= '0;
         edge_seen <= 1'b0;
      end else if (spi_ncs) begin
         lead_cnt  <= '0;
         edge_seen <= 1'b0;
      end else if (!spi_sclk) begin
         edge_seen <= 1'b1;
      end else if (!edge_seen && lead_cnt != 16'hFFFF) begin
         lead_cnt <= lead_cnt + 1'b1;
      end
   end

   a_r1_sclk_framed: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sclk) |-> !spi_ncs);

   a_r1_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   a_r2_lead_time: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(spi_sclk) && !edge_seen) |-> (lead_cnt >= 16'(T_LEAD)));

   a_r4_rdv_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(spi_ncs));

   a_r4_rdv_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> spi_ncs);

   a_r11_busy_framed: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_ncs |-> busy);

endmodule

bind spi_gap_host spi_gap_host_chk #(.T_LEAD(T_LEAD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rd_valid  (rd_valid),
   .busy      (busy),
   .spi_ncs   (spi_ncs),
   .spi_sclk  (spi_sclk),
   .spi_mosi  (spi_mosi)
);

// File: tb/spi_gap_host_test.sv
`timescale 1ns/1ps
module spi_gap_host_test;

   localparam int HALF = 3;
   localparam int TLD  = 4;
   localparam int TAD  = 20;
   localparam int LRD  = 5;
   localparam int LWR  = 25;
   localparam int TWW  = 60;
   localparam int TWR  = 45;
   localparam int TRN  = 10;
   localparam int TBX  = 30;
   localparam int TRH  = 300;
   localparam logic [6:0] RSTA = 7'h3A;

   typedef struct packed {
      logic       wr;
      logic       bst;
      logic [6:0] addr;
      logic [7:0] data;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_burst = 1'b0;
   logic [6:0] cmd_addr = '0;
   logic [7:0] cmd_wdata = '0;
   logic cmd_ready, rd_valid, busy, spi_ncs, spi_sclk, spi_mosi;
   logic [7:0] rd_data;
   logic miso_r = 1'b0;

   int checks = 0, fails = 0;
   bit done = 0;
   item_t exp_q[$];

   always #10 clk = ~clk;

   spi_gap_host #(
      .HALF_CYC(HALF), .T_LEAD(TLD), .T_ADDR_DATA(TAD), .T_LAG_RD(LRD),
      .T_LAG_WR(LWR), .T_WW(TWW), .T_WR(TWR), .T_RD_NEXT(TRN),
      .T_BURST_EXIT(TBX), .T_RESET_HOLD(TRH), .RST_ADDR(RSTA)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_burst(cmd_burst), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .busy(busy), .spi_ncs(spi_ncs), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(miso_r)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // 1 write, 2 read, 3 burst read, 4 reset write
   function automatic int kind_of(input item_t it);
      if (it.wr) return (it.addr == RSTA) ? 4 : 1;
      return it.bst ? 3 : 2;
   endfunction

   function automatic int need_of(input int k, input logic nxt_wr);
      case (k)
         1: return nxt_wr ? TWW : TWR;
         2: return TRN;
         3: return (TBX > TRN) ? TBX : TRN;
         4: return TRH;
         default: return 0;
      endcase
   endfunction

   function automatic int hold_of(input int k);
      if (k == 1) return (TWW > TWR) ? TWW : TWR;
      return need_of(k, 1'b0);
   endfunction

   function automatic logic [7:0] resp_of(input logic [7:0] ab);
      return 8'({1'b0, ab[6:0]} * 3 + 8'h11);
   endfunction

   // Driver: pushes the expected item, presents it, waits for acceptance
   task automatic send(input logic wr, input logic bst, input logic [6:0] a, input logic [7:0] d);
      item_t it;
      it.wr = wr; it.bst = bst; it.addr = a; it.data = d;
      exp_q.push_back(it);
      cmd_valid = 1'b1; cmd_write = wr; cmd_burst = bst;
      cmd_addr = a; cmd_wdata = d;
      do @(negedge clk); while (!cmd_ready);
      @(posedge clk);
      #2;
   endtask

   task automatic drain();
      cmd_valid = 1'b0;
      do @(negedge clk); while (exp_q.size() != 0 || busy || !spi_ncs);
      @(posedge clk);
      #2;
   endtask

   // Monitor, scoreboard and peripheral model
   logic ncs_p = 1'b1, sclk_p = 1'b1;
   logic [7:0] abyte, dbyte, resp;
   int bits, lead, lrun, hrun, hi_cnt, bcnt, prev_kind;
   bit started, have_prev, vheld, bdone, bad_frame;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid && !(spi_ncs && !ncs_p))
            check(1'b0, "R4 stray rd_valid", 1, 0);
         if (!spi_ncs && ncs_p) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1 unexpected frame", 1, 0);
            end else if (have_prev) begin
               if (vheld)
                  check(hi_cnt == need_of(prev_kind, exp_q[0].wr) + 1,
                        "R7/R8/R9/R10 held gap", hi_cnt, need_of(prev_kind, exp_q[0].wr) + 1);
               else
                  check(hi_cnt >= need_of(prev_kind, exp_q[0].wr) + 1,
                        "R7/R8/R9 gap", hi_cnt, need_of(prev_kind, exp_q[0].wr) + 1);
            end
            lead = 0; started = 0; bits = 0; lrun = 0; hrun = 0;
            bad_frame = 0; miso_r = 1'b0;
         end
         if (!spi_ncs) begin
            if (!busy || cmd_ready) bad_frame = 1;
            if (!started) begin
               if (spi_sclk) lead++;
               else begin
                  started = 1;
                  check(lead == TLD, "R2 lead", lead, TLD);
                  lrun = 1;
               end
            end else if (!spi_sclk && sclk_p) begin
               if (bits == 8 && exp_q.size() != 0 && !exp_q[0].wr)
                  check(hrun == HALF + TAD, "R5 addr-data pause", hrun, HALF + TAD);
               else
                  check(hrun == HALF, "R3 high phase", hrun, HALF);
               if (bits >= 8) miso_r = resp[4'(15 - bits)];
               lrun = 1;
            end else if (spi_sclk && !sclk_p) begin
               check(lrun == HALF, "R3 low phase", lrun, HALF);
               if (bits < 8) abyte = {abyte[6:0], spi_mosi};
               else          dbyte = {dbyte[6:0], spi_mosi};
               bits++;
               if (bits == 8) resp = resp_of(abyte);
               hrun = 1;
            end else if (spi_sclk) hrun++;
            else lrun++;
         end
         if (spi_ncs && !ncs_p && exp_q.size() != 0) begin
            item_t cur;
            cur = exp_q.pop_front();
            check(bits == 16, "R1 bit count", bits, 16);
            check(abyte == {cur.wr, cur.addr}, "R1 address byte", abyte, {cur.wr, cur.addr});
            check(hrun == HALF + (cur.wr ? LWR : LRD), "R6 release lag", hrun,
                  HALF + (cur.wr ? LWR : LRD));
            check(!bad_frame, "R10/R11 ready low, busy high in frame", bad_frame, 0);
            if (cur.wr) begin
               check(dbyte == cur.data, "R1 write data", dbyte, cur.data);
               check(rd_valid == 1'b0, "R4 no strobe on write", rd_valid, 0);
            end else begin
               check(dbyte == 8'h00, "R1 read filler", dbyte, 0);
               check(rd_valid == 1'b1, "R4 strobe", rd_valid, 1);
               check(rd_data == resp, "R4 read data", rd_data, resp);
            end
            prev_kind = kind_of(cur); have_prev = 1;
            hi_cnt = 0; vheld = 1; bcnt = 0; bdone = 0;
         end
         if (spi_ncs && have_prev) begin
            hi_cnt++;
            if (!cmd_valid) vheld = 0;
            if (!bdone) begin
               if (busy) bcnt++;
               else begin
                  bdone = 1;
                  check(bcnt == hold_of(prev_kind), "R11 busy tail", bcnt, hold_of(prev_kind));
               end
            end
         end
         ncs_p = spi_ncs; sclk_p = spi_sclk;
      end
   end

   initial begin
      have_prev = 0; started = 0; bits = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(spi_ncs && spi_sclk, "R12 lines idle high", {spi_ncs, spi_sclk}, 3);
      check(!busy && !rd_valid, "R12 busy/rd_valid low", {busy, rd_valid}, 0);
      check(cmd_ready, "R12 ready", cmd_ready, 1);
      @(posedge clk); #2;
      send(1'b1, 1'b0, 7'h12, 8'h5A);   // R1 write
      send(1'b1, 1'b0, 7'h13, 8'hC3);   // R7 write->write
      send(1'b0, 1'b0, 7'h20, 8'h00);   // R7 write->read
      send(1'b0, 1'b0, 7'h21, 8'h00);   // R8 read->read
      send(1'b0, 1'b1, 7'h50, 8'h00);   // burst read
      send(1'b1, 1'b0, 7'h02, 8'h00);   // R8 burst exit
      send(1'b0, 1'b1, 7'h7F, 8'h00);   // top address
      send(1'b0, 1'b0, 7'h00, 8'h00);   // bottom address after burst
      send(1'b1, 1'b0, 7'h7F, 8'hFF);
      drain();                          // R11 busy tail after write
      send(1'b1, 1'b0, RSTA, 8'h5A);    // R9 reset write
      send(1'b0, 1'b0, 7'h02, 8'h00);
      send(1'b1, 1'b0, 7'h05, 8'hA5);
      drain();
      repeat (50) @(posedge clk);
      #2;
      send(1'b0, 1'b0, 7'h33, 8'h00);   // paused caller, gap bound only
      drain();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule